// File: doc/BRIEF.md
# Search coprocessor SRAM write sequencer

This block sits on the device side of a search coprocessor. It watches the host command/data bus for a Write command and turns each accepted Write into one write cycle on the external associated SRAM. The block drives the SRAM address and its active-low chip-enable and write-enable strobes. The SRAM data path is not part of this block.

A Write fills four consecutive clocks on the host bus. The first clock is the address phase (A). The second clock is the confirm phase (B), in which the host repeats the command. The last two clocks are filler clocks, and the block ignores whatever the host drives during them. The address phase decides three things: whether the command is for this device (a 5-bit ID compare), whether it targets SRAM space, and which SRAM address is written.

The accepted write goes through a token-and-address delay line. It therefore reaches the SRAM pins after the configured search latency instead of at once. Commands can be issued back to back, every four clocks, and none of them are lost.

Top module: `srch_sram_wr`

## Requirements
- R1: While reset is asserted and right after it is released, ce_no, we_no and oe_no are 1 and sadr_o is 0.
- R2: A command starts only in a clock where cmdv_i is 1 and cmd_i[1:0] is 2'b01. It produces a write only if the next clock (phase B) again has cmdv_i 1 and cmd_i[1:0] 2'b01. Once started, the command fills four clocks whether or not phase B confirms it.
- R3: A write happens only when dq_i[25:21] in phase A equals dev_id_i.
- R4: A write happens only when dq_i[20:19] in phase A equals 2'b10. The values 2'b00, 2'b01 and 2'b11 produce no write.
- R5: The written address is sadr_o[23:21] = cmd_i[8:6], sadr_o[20:19] = 2'b00 and sadr_o[18:0] = dq_i[18:0]. All of these bits are taken in phase A.
- R6: Take the rising edge that samples phase B as edge 1. The strobes go low right after edge lat_i+2, where lat_i is a value from 0 to 7.
- R7: Each accepted write drives ce_no and we_no low together for exactly one clock. oe_no stays 1 at all times.
- R8: sadr_o changes only at the edge where the strobes go low, and it holds its value in every other clock.
- R9: The two clocks after phase B are ignored, even if they carry a matching Write. A new command may start in the clock right after them.
- R10: Writes issued every four clocks each produce exactly one SRAM write, in issue order, at every latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmdv_i | input | 1 | Command valid |
| cmd_i | input | 11 | Command bits: [1:0] opcode, [8:6] upper SRAM address |
| dq_i | input | 72 | Host data bus: [25:21] target ID, [20:19] space, [18:0] low address |
| dev_id_i | input | 5 | This device's ID |
| lat_i | input | 3 | Search latency in extra clocks; held constant while writes are in flight |
| sadr_o | output | 24 | SRAM address |
| ce_no | output | 1 | SRAM chip enable, active low |
| we_no | output | 1 | SRAM write enable, active low |
| oe_no | output | 1 | SRAM output enable, active low, held high |

## Verification
The filler clocks always carry a fully matching Write pattern. A decoder that goes back to its idle state too early would therefore start a second, phantom write, and the bench sees it as an extra strobe. A failed phase B must still use up four clocks, so it is followed by a pattern that would be accepted if the slot had been freed early. Every latency from 0 to 7 is swept, and back-to-back bursts are run at the shortest and longest delay. An off-by-one in the delay tap, or a delay line that overwrites an address still in flight, shows up as a strobe in the wrong clock or as a wrong or reordered sadr_o. A design that uses the confirm phase's address bits, or keeps the space bits in the address, is caught because phase B and the fillers carry different low-address values.

// File: rtl/srch_wr_pkg.sv
package srch_wr_pkg;
  localparam int DQ_W    = 72;
  localparam int CMD_W   = 11;
  localparam int ID_W    = 5;
  localparam int SADR_W  = 24;
  localparam int ID_LSB  = 21;
  localparam int SPC_LSB = 19;
  localparam int LO_W    = 19;
  localparam int HI_LSB  = 6;
  localparam int HI_W    = 3;
  localparam int GAP_W   = SADR_W - HI_W - LO_W;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] SPC_SRAM = 2'b10;

  typedef enum logic [1:0] {
    ST_ADDR,
    ST_CONF,
    ST_FILL1,
    ST_FILL2
  } dec_st_e;
endpackage

// File: rtl/srch_wr_decode.sv
module srch_wr_decode
  import srch_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmdv_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id_i,
  output logic              tok_o,
  output logic [SADR_W-1:0] addr_o
);
  dec_st_e           st_q;
  logic              hit_q;
  logic [SADR_W-1:0] addr_q;
  logic              wr_cmd;
  logic              id_hit;
  logic              spc_hit;

  assign wr_cmd  = cmdv_i && (cmd_i[1:0] == OP_WRITE);
  assign id_hit  = dq_i[ID_LSB +: ID_W] == dev_id_i;
  assign spc_hit = dq_i[SPC_LSB +: 2] == SPC_SRAM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ADDR;
      hit_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (wr_cmd) begin
          st_q   <= ST_CONF;
          hit_q  <= id_hit && spc_hit;
          addr_q <= {cmd_i[HI_LSB +: HI_W], {GAP_W{1'b0}}, dq_i[LO_W-1:0]};
        end
        ST_CONF:  st_q <= ST_FILL1;
        ST_FILL1: st_q <= ST_FILL2;
        default:  st_q <= ST_ADDR;
      endcase
    end
  end

  // token issued in the confirm phase only
  assign tok_o  = (st_q == ST_CONF) && wr_cmd && hit_q;
  assign addr_o = addr_q;

  // R2
  tok_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |-> $past(cmdv_i));

  // R9
  tok_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |-> !$past(tok_o));
endmodule

// File: rtl/srch_wr_pipe.sv
module srch_wr_pipe #(
  parameter int DEPTH = 8,
  parameter int W     = 24,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_i,
  input  logic [W-1:0]     addr_i,
  input  logic [SEL_W-1:0] lat_i,
  output logic             tok_o,
  output logic [W-1:0]     addr_o
);
  logic [DEPTH-1:0] tok_q;
  logic [W-1:0]     addr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic         tok_d;
    logic [W-1:0] addr_d;
    if (g == 0) begin : g_head
      assign tok_d  = tok_i;
      assign addr_d = addr_i;
    end else begin : g_body
      assign tok_d  = tok_q[g-1];
      assign addr_d = addr_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tok_q[g]  <= 1'b0;
        addr_q[g] <= '0;
      end else begin
        tok_q[g]  <= tok_d;
        addr_q[g] <= addr_d;
      end
    end
  end

  assign tok_o  = tok_q[lat_i];
  assign addr_o = addr_q[lat_i];
endmodule

// File: rtl/srch_wr_drv.sv
module srch_wr_drv #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tok_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] sadr_o,
  output logic         ce_no,
  output logic         we_no,
  output logic         oe_no
);
  logic [W-1:0] sadr_q;
  logic         ce_q;
  logic         we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sadr_q <= '0;
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
    end else begin
      ce_q <= !tok_i;
      we_q <= !tok_i;
      if (tok_i) sadr_q <= addr_i;
    end
  end

  assign sadr_o = sadr_q;
  assign ce_no  = ce_q;
  assign we_no  = we_q;
  assign oe_no  = 1'b1;

  // R7
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |=> we_no);

  // R7
  ce_we_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_no == we_no);

  // R8
  sadr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_no |-> $stable(sadr_o));
endmodule

// File: rtl/srch_sram_wr.sv
module srch_sram_wr
  import srch_wr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LAT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmdv_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic [SADR_W-1:0] sadr_o,
  output logic              ce_no,
  output logic              we_no,
  output logic              oe_no
);
  logic              dec_tok;
  logic [SADR_W-1:0] dec_addr;
  logic              dly_tok;
  logic [SADR_W-1:0] dly_addr;

  srch_wr_decode u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmdv_i   (cmdv_i),
    .cmd_i    (cmd_i),
    .dq_i     (dq_i),
    .dev_id_i (dev_id_i),
    .tok_o    (dec_tok),
    .addr_o   (dec_addr)
  );

  srch_wr_pipe #(.DEPTH(DEPTH), .W(SADR_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tok_i  (dec_tok),
    .addr_i (dec_addr),
    .lat_i  (lat_i),
    .tok_o  (dly_tok),
    .addr_o (dly_addr)
  );

  srch_wr_drv #(.W(SADR_W)) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tok_i  (dly_tok),
    .addr_i (dly_addr),
    .sadr_o (sadr_o),
    .ce_no  (ce_no),
    .we_no  (we_no),
    .oe_no  (oe_no)
  );
endmodule

// File: tb/srch_sram_wr_bench.sv
module srch_sram_wr_bench;
  localparam logic [4:0] DEV = 5'd14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdv = 1'b0;
  logic [10:0] cmd = '0;
  logic [71:0] dq = '0;
  logic [2:0]  lat = 3'd0;
  logic [23:0] sadr;
  logic        ce_n, we_n, oe_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_exp = 0;
  int n_seen = 0;
  int due_q[$];
  logic [23:0] adr_q[$];
  logic [23:0] last_sadr = '0;
  string cur_tag = "R1";
  bit run = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  srch_sram_wr u_srch_sram_wr (
    .clk_i(clk), .rst_ni(rst_n), .cmdv_i(cmdv), .cmd_i(cmd), .dq_i(dq),
    .dev_id_i(DEV), .lat_i(lat), .sadr_o(sadr), .ce_no(ce_n), .we_no(we_n), .oe_no(oe_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n && run) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        last_sadr = adr_q[0];
        void'(due_q.pop_front());
        void'(adr_q.pop_front());
        chk(we_n == 1'b0, {cur_tag, " R6 we_no"}, 32'(we_n), 32'd0);
        chk(ce_n == 1'b0, {cur_tag, " R7 ce_no"}, 32'(ce_n), 32'd0);
        chk(sadr == last_sadr, {cur_tag, " R5 sadr"}, 32'(sadr), 32'(last_sadr));
      end else begin
        chk(we_n == 1'b1, {cur_tag, " R7 we_no idle"}, 32'(we_n), 32'd1);
        chk(ce_n == 1'b1, {cur_tag, " R7 ce_no idle"}, 32'(ce_n), 32'd1);
        chk(sadr == last_sadr, {cur_tag, " R8 sadr hold"}, 32'(sadr), 32'(last_sadr));
      end
      chk(oe_n == 1'b1, "R7 oe_no", 32'(oe_n), 32'd1);
      if (!we_n) n_seen++;
    end
  end

  task automatic drive(input bit v, input logic [1:0] op, input logic [4:0] id,
                       input logic [1:0] spc, input logic [2:0] hi, input logic [18:0] lo);
    cmdv = v;
    cmd  = {2'b11, hi, 4'b1010, op};
    dq   = {{46{1'b1}}, id, spc, lo};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmdv = 1'b0;
      cmd  = '0;
      dq   = '0;
    end
  endtask

  task automatic issue(input bit v, input logic [1:0] op, input bit b_ok, input logic [4:0] id,
                       input logic [1:0] spc, input logic [2:0] hi, input logic [18:0] lo);
    @(negedge clk);
    drive(v, op, id, spc, hi, lo);
    if (!(v && op == 2'b01)) return;
    @(negedge clk);
    // phase B carries a different low address; only phase A counts
    if (b_ok) drive(1'b1, 2'b01, id, spc, ~hi, ~lo);
    else      drive(1'b0, 2'b01, id, spc, hi, lo);
    if (b_ok && id == DEV && spc == 2'b10) begin
      due_q.push_back(cyc + 2 + int'(lat));
      adr_q.push_back({hi, 2'b00, lo});
      n_exp++;
    end
    // R9: fillers look like a matching write
    @(negedge clk);
    drive(1'b1, 2'b01, DEV, 2'b10, 3'd5, 19'h7_1234);
    @(negedge clk);
    drive(1'b1, 2'b01, DEV, 2'b10, 3'd2, 19'h0_4321);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1 during reset
    chk(ce_n && we_n && oe_n, "R1 strobes in reset", {29'd0, ce_n, we_n, oe_n}, 32'd7);
    chk(sadr == '0, "R1 sadr in reset", 32'(sadr), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 strobes after reset", {29'd0, ce_n, we_n, oe_n}, 32'd7);
    chk(sadr == '0, "R1 sadr after reset", 32'(sadr), 32'd0);
    run = 1'b1;

    cur_tag = "R6";
    for (int l = 0; l < 8; l++) begin
      lat = 3'(l);
      issue(1'b1, 2'b01, 1'b1, DEV, 2'b10, 3'(l), 19'h1_0000 + 19'(l * 19'h111));
      idle(12);
    end

    cur_tag = "R3";
    lat = 3'd2;
    issue(1'b1, 2'b01, 1'b1, DEV ^ 5'd1, 2'b10, 3'd1, 19'h0_0ABC);
    issue(1'b1, 2'b01, 1'b1, 5'd0, 2'b10, 3'd1, 19'h0_0ABD);
    idle(12);

    cur_tag = "R4";
    issue(1'b1, 2'b01, 1'b1, DEV, 2'b00, 3'd3, 19'h0_1111);
    issue(1'b1, 2'b01, 1'b1, DEV, 2'b01, 3'd3, 19'h0_2222);
    issue(1'b1, 2'b01, 1'b1, DEV, 2'b11, 3'd3, 19'h0_3333);
    idle(12);

    cur_tag = "R2";
    issue(1'b0, 2'b01, 1'b1, DEV, 2'b10, 3'd4, 19'h0_4444);
    issue(1'b1, 2'b00, 1'b1, DEV, 2'b10, 3'd4, 19'h0_5555);
    issue(1'b1, 2'b10, 1'b1, DEV, 2'b10, 3'd4, 19'h0_6666);
    issue(1'b1, 2'b01, 1'b0, DEV, 2'b10, 3'd4, 19'h0_7777);
    issue(1'b1, 2'b01, 1'b1, DEV, 2'b10, 3'd6, 19'h5_A5A5);
    idle(12);

    cur_tag = "R10";
    for (int s = 0; s < 2; s++) begin
      lat = (s == 0) ? 3'd7 : 3'd0;
      for (int k = 0; k < 6; k++)
        issue(1'b1, 2'b01, 1'b1, (k == 3) ? DEV + 5'd1 : DEV, 2'b10, 3'(k), 19'h2_0000 + 19'(k * 19'h1357));
      idle(14);
    end

    cur_tag = "R9";
    lat = 3'd3;
    issue(1'b1, 2'b01, 1'b0, DEV, 2'b10, 3'd1, 19'h0_0001);
    issue(1'b1, 2'b01, 1'b1, DEV, 2'b10, 3'd7, 19'h7_FFFF);
    idle(14);

    chk(due_q.size() == 0, "R10 pending writes", 32'(due_q.size()), 32'd0);
    chk(n_seen == n_exp, "R10 write count", 32'(n_seen), 32'(n_exp));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule